// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Pair

This block holds two identical down-counting timer channels reached through a small memory-mapped register window. Software writes a start value into a reload register, then sets count enable together with a trigger bit in the channel's control word. The counter loads from the reload register and steps down once every two clock cycles. When a tick arrives while the counter already stands at zero, the channel records an underflow.

An underflow sets a sticky flag, toggles a per-channel output pin, and raises a level interrupt when interrupts are enabled for that channel. With reload enabled the channel reloads and keeps running, so it gives a periodic tick. With reload disabled the channel stops with the counter at zero. Software clears the flag with a read-modify-write that writes zero to the flag bit. A second reload register per channel is plain storage.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every register of both channels reads 0, and both `irq` bits and both `tout` bits are 0.
- R2: Byte address bit 4 selects the channel (0x00 for channel 0, 0x10 for channel 1). Address bits [3:2] select the register: 0x0 control, 0x4 counter, 0x8 reload 1, 0xC reload 2. Reload 2 is read/write storage that has no effect on counting. The channels are independent.
- R3: Writing control bit 0 (trigger) as 1 loads the counter from reload 1 at that write's clock edge and restarts the prescaler. Bit 0 always reads back 0, and the trigger loads the counter even when count enable is clear.
- R4: While control bit 1 (count enable) is set, the counter decrements once every 2 clock cycles, with the first decrement 2 cycles after the trigger. While bit 1 is clear, the counter holds its value.
- R5: A tick that arrives while the counter is 0 is an underflow, and it sets control bit 2 (underflow flag). When control bit 4 (reload enable) is 0, the underflow also clears count enable and leaves the counter at 0. A start value N therefore underflows 2*(N+1) cycles after the trigger.
- R6: When reload enable is 1, each underflow reloads the counter from reload 1 and counting continues, which gives a period of 2*(N+1) cycles.
- R7: Writing 0 to control bit 2 clears the underflow flag. Writing 1 to it leaves the flag unchanged.
- R8: `irq[c]` is high exactly while channel c's underflow flag and control bit 3 (interrupt enable) are both set.
- R9: `tout[c]` toggles on every underflow of channel c. Control bit 5 (output level) inverts its polarity as soon as it is written.
- R10: Reads are registered: `rdData` shows the addressed register value that was present at the clock edge where `rdEn` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 5 | Byte address within the register window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| irq | output | 2 | Per-channel level interrupt |
| tout | output | 2 | Per-channel toggle output |

## Verification
The hardest cases to reach from the ports are the exact underflow edge and the periodic reload. Both depend on the prescaler phase that the trigger sets up. The bench starts every timed scenario with a trigger write at a known edge, then counts negative edges from that point. It samples `irq` and `tout` one cycle before and one cycle after the predicted underflow edge of 2*(N+1) cycles. Flag clearing is probed separately: after the periodic run has left the flag set, the bench writes the control word with the flag bit at 1 and then at 0.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  typedef enum logic [1:0] {
    RegCsr  = 2'd0,
    RegCnt  = 2'd1,
    RegRld1 = 2'd2,
    RegRld2 = 2'd3
  } regSel_e;

  typedef struct packed {
    logic trigLoad;
    logic decrement;
    logic reload;
    logic wrCnt;
    logic wrRld1;
    logic wrRld2;
  } dpStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import dual_timer_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chWr,
  input  regSel_e          regSel,
  input  logic [DataW-1:0] wrData,
  input  logic             cntZero,
  output dpStrobe_t        strobe,
  output logic [DataW-1:0] csrRd,
  output logic             irq,
  output logic             tout
);
  logic outLvl, reldEn, intEn, ufFlag, cntEn, presc, togState;
  logic tick, ufEvt, wrCsr, trig;

  assign wrCsr = chWr && (regSel == RegCsr);
  assign trig  = wrCsr && wrData[0];
  assign tick  = cntEn && presc;
  assign ufEvt = tick && cntZero;

  always_comb begin
    strobe           = '0;
    strobe.trigLoad  = trig;
    strobe.decrement = tick && !cntZero && !trig;
    strobe.reload    = ufEvt && reldEn && !trig;
    strobe.wrCnt     = chWr && (regSel == RegCnt);
    strobe.wrRld1    = chWr && (regSel == RegRld1);
    strobe.wrRld2    = chWr && (regSel == RegRld2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLvl   <= 1'b0;
      reldEn   <= 1'b0;
      intEn    <= 1'b0;
      ufFlag   <= 1'b0;
      cntEn    <= 1'b0;
      presc    <= 1'b0;
      togState <= 1'b0;
    end else begin
      if (trig || !cntEn) presc <= 1'b0;
      else                presc <= ~presc;

      if (wrCsr) begin
        outLvl <= wrData[5];
        reldEn <= wrData[4];
        intEn  <= wrData[3];
        cntEn  <= wrData[1];
      end else if (ufEvt && !reldEn) begin
        cntEn  <= 1'b0;
      end

      ufFlag <= (wrCsr ? (ufFlag & wrData[2]) : ufFlag) | ufEvt;

      if (ufEvt) togState <= ~togState;
    end
  end

  always_comb begin
    csrRd    = '0;
    csrRd[5] = outLvl;
    csrRd[4] = reldEn;
    csrRd[3] = intEn;
    csrRd[2] = ufFlag;
    csrRd[1] = cntEn;
  end

  assign irq  = ufFlag && intEn;
  assign tout = togState ^ outLvl;

  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ufEvt && !reldEn && !wrCsr) |=> !cntEn);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ufFlag && !(wrCsr && !wrData[2])) |=> ufFlag);
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !wrCsr) |=> irq);
  p_tout_toggle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ufEvt && !wrCsr) |=> (tout != $past(tout)));
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import dual_timer_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] cnt,
  output logic [DataW-1:0] rld1,
  output logic [DataW-1:0] rld2,
  output logic             cntZero
);
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      rld1 <= '0;
      rld2 <= '0;
    end else begin
      if (strobe.wrRld1) rld1 <= wrData;
      if (strobe.wrRld2) rld2 <= wrData;
      if (strobe.trigLoad)       cnt <= rld1;
      else if (strobe.wrCnt)     cnt <= wrData;
      else if (strobe.reload)    cnt <= rld1;
      else if (strobe.decrement) cnt <= cnt - 1'b1;
    end
  end

  p_dec_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decrement && !strobe.wrCnt) |=> (cnt == $past(cnt) - 1'b1));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && !strobe.wrCnt) |=> (cnt == $past(rld1)));
  p_trig_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trigLoad |=> (cnt == $past(rld1)));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import dual_timer_pkg::*;
#(
  parameter int NumCh = 2,
  parameter int DataW = 32,
  localparam int ChW   = (NumCh > 1) ? $clog2(NumCh) : 1,
  localparam int AddrW = ChW + 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdData,
  output logic [NumCh-1:0] irq,
  output logic [NumCh-1:0] tout
);
  logic [ChW-1:0]   chIdx;
  regSel_e          regSel;
  logic [DataW-1:0] regVal [NumCh][4];

  assign chIdx  = addr[AddrW-1:4];
  assign regSel = regSel_e'(addr[3:2]);

  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    dpStrobe_t        strobe;
    logic             cntZero;
    logic             chWr;

    assign chWr = wrEn && (int'(chIdx) == c);

    timer_ctrl #(.DataW(DataW)) u_ctrl (
      .clk    (clk),
      .rstN   (rstN),
      .chWr   (chWr),
      .regSel (regSel),
      .wrData (wrData),
      .cntZero(cntZero),
      .strobe (strobe),
      .csrRd  (regVal[c][0]),
      .irq    (irq[c]),
      .tout   (tout[c])
    );

    timer_datapath #(.DataW(DataW)) u_dp (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .wrData (wrData),
      .cnt    (regVal[c][1]),
      .rld1   (regVal[c][2]),
      .rld2   (regVal[c][3]),
      .cntZero(cntZero)
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) begin
      if (int'(chIdx) < NumCh) rdData <= regVal[chIdx][addr[3:2]];
      else                     rdData <= '0;
    end
  end
endmodule

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
  localparam time ClkPeriod = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  irq, tout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(ClkPeriod / 2) clk = ~clk;

  dual_reload_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .tout(tout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), v);
      chk($sformatf("R1 reg 0x%0h", a), v, 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 tout", 32'(tout), 32'h0);
  endtask

  task automatic test_map();
    logic [31:0] v;
    wr(5'h1C, 32'hA5A5_0F0F);
    wr(5'h18, 32'h0000_1234);
    rd(5'h1C, v); chk("R2 ch1 reload2", v, 32'hA5A5_0F0F);
    rd(5'h18, v); chk("R2 ch1 reload1", v, 32'h0000_1234);
    rd(5'h0C, v); chk("R2 ch0 reload2 untouched", v, 32'h0);
    rd(5'h14, v); chk("R2 ch1 counter unaffected", v, 32'h0);
  endtask

  task automatic test_trigger();
    logic [31:0] v;
    wr(5'h08, 32'd7);
    wr(5'h00, 32'h01);
    rd(5'h04, v); chk("R3 trigger load", v, 32'd7);
    rd(5'h00, v); chk("R3 trigger reads 0", v, 32'h0);
    repeat (6) @(negedge clk);
    rd(5'h04, v); chk("R4 no count without enable", v, 32'd7);
  endtask

  task automatic test_decrement();
    logic [31:0] v;
    wr(5'h08, 32'd100);
    wr(5'h00, 32'h03);
    rd(5'h04, v); chk("R4 value before first tick", v, 32'd100);
    repeat (9) @(negedge clk);
    rd(5'h04, v); chk("R4 five ticks in ten cycles", v, 32'd95);
    wr(5'h00, 32'h00);
    rd(5'h04, v);
    repeat (8) @(negedge clk);
    begin
      logic [31:0] w;
      rd(5'h04, w); chk("R4 hold when disabled", w, v);
    end
  endtask

  task automatic test_oneshot();
    logic [31:0] v;
    wr(5'h08, 32'd3);
    wr(5'h00, 32'h0B);
    repeat (7) @(negedge clk);
    chk("R5 no underflow yet", 32'(irq[0]), 32'h0);
    @(negedge clk);
    chk("R8 irq at underflow", 32'(irq[0]), 32'h1);
    chk("R9 tout toggled", 32'(tout[0]), 32'h1);
    chk("R2 ch1 irq quiet", 32'(irq[1]), 32'h0);
    rd(5'h00, v); chk("R5 flag set, enable cleared", v, 32'h0C);
    rd(5'h04, v); chk("R5 counter left at 0", v, 32'h0);
    wr(5'h00, 32'h08);
    chk("R8 irq drops on flag clear", 32'(irq[0]), 32'h0);
  endtask

  task automatic test_periodic();
    logic [31:0] v;
    wr(5'h08, 32'd2);
    wr(5'h00, 32'h13);
    repeat (5) @(negedge clk);
    chk("R6 tout before first underflow", 32'(tout[0]), 32'h1);
    @(negedge clk);
    chk("R6 first underflow", 32'(tout[0]), 32'h0);
    chk("R8 no irq when disabled", 32'(irq[0]), 32'h0);
    repeat (5) @(negedge clk);
    chk("R6 before second underflow", 32'(tout[0]), 32'h0);
    @(negedge clk);
    chk("R6 second underflow after reload", 32'(tout[0]), 32'h1);
    wr(5'h00, 32'h04);
    chk("R9 tout level with polarity 0", 32'(tout[0]), 32'h1);
    wr(5'h00, 32'h24);
    chk("R9 polarity inverted", 32'(tout[0]), 32'h0);
    rd(5'h00, v); chk("R7 write 1 keeps flag", v, 32'h24);
    wr(5'h00, 32'h20);
    rd(5'h00, v); chk("R7 write 0 clears flag", v, 32'h20);
    wr(5'h00, 32'h24);
    rd(5'h00, v); chk("R7 write 1 does not set flag", v, 32'h20);
    rd(5'h10, v); chk("R10 ch1 control untouched", v, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_map();
    test_trigger();
    test_decrement();
    test_oneshot();
    test_periodic();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule